// File: doc/BRIEF.md
# Flash Read Idle Power Detector

This block decides when a flash read port may drop into a near-standby power state and when it must leave it. It runs on a free-running sample clock and watches the port's address, chip-enable, output-enable, address-valid and bus clock pins. All time thresholds are counts of that sample clock. Two idle rules exist, and a mode input selects between them. In asynchronous read mode, an ongoing read whose address and controls stay quiet for the access time plus an idle margin enters low power. In synchronous read mode, a falling address-valid that is not followed by a bus clock edge within the idle margin enters low power.

While low power is asserted, the output data register holds the last word read, so the host keeps valid data with no added latency. Any activity that starts a new access takes the block out of low power. The output register then loads fresh array data on the same sample edge. When the chip is deselected and not held in device reset, a separate standby flag is raised and low power is forced off.

Top module: `lp_idle_detector`

## Requirements
- R1: While `rst_n` is low, `low_power` is 0 and `data_out` is 0. `standby` is 1 exactly when `ce_n`=1 and `dev_rst_n`=1.
- R2: In asynchronous mode (`sync_mode`=0) with `ce_n`=0, `oe_n`=0 and `dev_rst_n`=1, `low_power` goes to 1 after ACC_CYCLES+IDLE_CYCLES consecutive sample edges with no activity. Activity means an address change, or a falling edge of `ce_n`, `oe_n` or `adv_n`.
- R3: In asynchronous mode, an address change or a falling `oe_n`, `ce_n` or `adv_n` seen at a sample edge clears `low_power` after that edge, and the idle count restarts from zero.
- R4: In asynchronous mode, `low_power` stays 0 while `oe_n`=1, because no read is in progress.
- R5: In synchronous mode (`sync_mode`=1), a falling `adv_n` arms the detector. If IDLE_CYCLES further sample edges pass with no rising `bus_clk`, `low_power` goes to 1.
- R6: In synchronous mode, a rising `bus_clk` clears `low_power` after that edge and disarms the detector. Low power is not entered again until the next falling `adv_n`.
- R7: While `low_power` is 1, `data_out` does not change. At every other edge, `data_out` loads `array_data`, including the edge at which low power is left.
- R8: Whenever `ce_n`=1 or `dev_rst_n`=0, `low_power` is 0 and both idle counts restart. `standby` equals `ce_n` AND `dev_rst_n`.
- R9: In synchronous mode, address changes have no effect on `low_power`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sample clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| sync_mode | input | 1 | 0 = asynchronous read rule, 1 = synchronous read rule |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| adv_n | input | 1 | Address valid strobe, active low |
| dev_rst_n | input | 1 | Device reset pin level, active low |
| bus_clk | input | 1 | Read bus clock level, sampled |
| addr | input | ADDR_W | Read address |
| array_data | input | DATA_W | Word from the read path |
| data_out | output | DATA_W | Held output word |
| low_power | output | 1 | Near-standby request to the power controller |
| standby | output | 1 | Deselected standby indication |

## Verification
The checker watches four things on every cycle:
- `standby` and `low_power` are never both high.
- `data_out` stays frozen across consecutive low-power cycles.
- An address change in asynchronous mode, or a bus clock rise in synchronous mode, is followed by `low_power` low.
- Low power only rises while the chip is selected.

The exact entry edge after ACC_CYCLES+IDLE_CYCLES or IDLE_CYCLES quiet edges can only be shown by the bench's scenarios. The same holds for the absence of entry with `oe_n` high, for disarming after a clock edge, and for insensitivity to addresses in synchronous mode. For these, the bench's reference model is compared against the outputs on every clock.

// File: rtl/lp_idle_pkg.sv
// Shared types for the idle power detector.
// Assumes: nothing beyond IEEE 1800-2017.
package lp_idle_pkg;

    // Which idle rule governs low-power entry.
    typedef enum logic {
        RD_ASYNC = 1'b0,
        RD_SYNC  = 1'b1
    } rd_mode_e;

    // Event flags produced by the bus watcher, one per sample edge.
    typedef struct packed {
        logic addr_chg;
        logic ce_fall;
        logic oe_fall;
        logic adv_fall;
        logic bclk_rise;
    } bus_evt_t;

endpackage

// File: rtl/lp_bus_watch.sv
// Bus watcher: keeps the previous sample of each watched pin and flags
// transitions between the previous and the present sample.
// Assumes: all inputs are already synchronous to clk.
module lp_bus_watch
    import lp_idle_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              adv_n,
    input  logic              bus_clk,
    output bus_evt_t          evt
);

    logic [ADDR_W-1:0] addr_q;
    logic              ce_q, oe_q, adv_q, bclk_q;

    // Capture the previous sample; idle levels after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            ce_q   <= 1'b1;
            oe_q   <= 1'b1;
            adv_q  <= 1'b1;
            bclk_q <= 1'b0;
        end else begin
            addr_q <= addr;
            ce_q   <= ce_n;
            oe_q   <= oe_n;
            adv_q  <= adv_n;
            bclk_q <= bus_clk;
        end
    end

    // Compare present against previous sample.
    always_comb begin
        evt.addr_chg  = (addr != addr_q);
        evt.ce_fall   = ce_q & ~ce_n;
        evt.oe_fall   = oe_q & ~oe_n;
        evt.adv_fall  = adv_q & ~adv_n;
        evt.bclk_rise = ~bclk_q & bus_clk;
    end

endmodule

// File: rtl/lp_quiet_timer.sv
// Quiet timer: a saturating counter that restarts on clr_i and steps
// on inc_i, reporting when it holds LIMIT (now and at the next edge).
// Assumes: LIMIT >= 1.
module lp_quiet_timer #(
    parameter int unsigned LIMIT = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic reached_o,
    output logic reaching_o
);

    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q, cnt_d;

    // Next count: restart, step, or hold at the limit.
    always_comb begin
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && (cnt_q != LIM)) begin
            cnt_d = cnt_q + 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign reached_o  = (cnt_q == LIM);
    assign reaching_o = (cnt_d == LIM);

endmodule

// File: rtl/lp_idle_detector.sv
// Idle power detector top. It applies the asynchronous rule (quiet
// address and controls during a read for ACC_CYCLES+IDLE_CYCLES) or the
// synchronous rule (no bus clock rise for IDLE_CYCLES after an
// address-valid fall). It holds output data while in low power.
// Assumes: inputs synchronous to clk; clk is free-running.
module lp_idle_detector
    import lp_idle_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned ACC_CYCLES  = 18,
    parameter int unsigned IDLE_CYCLES = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_mode,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              adv_n,
    input  logic              dev_rst_n,
    input  logic              bus_clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] data_out,
    output logic              low_power,
    output logic              standby
);

    localparam int unsigned ASYNC_LIMIT = ACC_CYCLES + IDLE_CYCLES;

    rd_mode_e    mode;
    bus_evt_t    evt;
    logic        off, act_async;
    logic        a_clr, a_hit, a_reach;
    logic        s_clr, s_hit, s_reach;
    logic        armed_q;
    logic        lp_next;

    assign mode = rd_mode_e'(sync_mode);
    assign off  = ce_n | ~dev_rst_n;

    lp_bus_watch #(.ADDR_W(ADDR_W)) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .adv_n   (adv_n),
        .bus_clk (bus_clk),
        .evt     (evt)
    );

    // Any access-starting activity under the asynchronous rule.
    assign act_async = evt.addr_chg | evt.ce_fall | evt.oe_fall | evt.adv_fall;

    // Asynchronous rule: count quiet edges of an ongoing read.
    assign a_clr = (mode == RD_SYNC) | off | oe_n | act_async;

    lp_quiet_timer #(.LIMIT(ASYNC_LIMIT)) u_async_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (a_clr),
        .inc_i      (1'b1),
        .reached_o  (a_hit),
        .reaching_o (a_reach)
    );

    // Synchronous rule: count edges since address-valid fall, no clock rise.
    assign s_clr = (mode == RD_ASYNC) | off | evt.adv_fall | evt.bclk_rise;

    lp_quiet_timer #(.LIMIT(IDLE_CYCLES)) u_sync_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (s_clr),
        .inc_i      (armed_q),
        .reached_o  (s_hit),
        .reaching_o (s_reach)
    );

    // Arm on address-valid fall; disarm on clock rise or deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if ((mode == RD_ASYNC) || off || evt.bclk_rise) begin
            armed_q <= 1'b0;
        end else if (evt.adv_fall) begin
            armed_q <= 1'b1;
        end
    end

    assign lp_next = a_reach | s_reach;

    // Output word: follow the read path unless low power holds next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out <= '0;
        end else if (!lp_next) begin
            data_out <= array_data;
        end
    end

    assign low_power = ~off & (a_hit | s_hit);
    assign standby   = ce_n & dev_rst_n;

endmodule

// File: rtl/lp_idle_checker.sv
// Checker for lp_idle_detector, attached by bind below.
// Assumes: the same clock and synchronous reset as the detector.
module lp_idle_checker #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sync_mode,
    input logic              ce_n,
    input logic              bus_clk,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] data_out,
    input logic              low_power,
    input logic              standby
);

    // R8
    standby_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(standby && low_power));

    // R7
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_power && $past(low_power)) |-> $stable(data_out));

    // R3
    async_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode && !ce_n && addr != $past(addr)) |=> !low_power);

    // R6
    sync_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && bus_clk && !$past(bus_clk)) |=> !low_power);

    // R8
    entry_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_power) |-> !ce_n);

endmodule

bind lp_idle_detector lp_idle_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_mode (sync_mode),
    .ce_n      (ce_n),
    .bus_clk   (bus_clk),
    .addr      (addr),
    .data_out  (data_out),
    .low_power (low_power),
    .standby   (standby)
);

// File: tb/lp_idle_detector_test.sv
// Bench for lp_idle_detector: a behavioural reference model updated at
// each rising edge and compared at each falling edge.
module lp_idle_detector_test;

    localparam int AW   = 16;
    localparam int DW   = 16;
    localparam int ACC  = 18;
    localparam int IDLE = 15;
    localparam int ATH  = ACC + IDLE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_mode = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          dev_rst_n = 1'b1;
    logic          bus_clk = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] array_data = '0;
    wire  [DW-1:0] data_out;
    wire           low_power;
    wire           standby;

    lp_idle_detector #(.ADDR_W(AW), .DATA_W(DW), .ACC_CYCLES(ACC), .IDLE_CYCLES(IDLE)) uut (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .ce_n(ce_n), .oe_n(oe_n),
        .adv_n(adv_n), .dev_rst_n(dev_rst_n), .bus_clk(bus_clk), .addr(addr),
        .array_data(array_data), .data_out(data_out), .low_power(low_power),
        .standby(standby)
    );

    always #2 clk = ~clk;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // Reference model state.
    int            m_acnt = 0, m_scnt = 0;
    bit            m_armed = 0;
    logic [AW-1:0] m_paddr = '0;
    bit            m_pce = 1, m_poe = 1, m_padv = 1, m_pbclk = 0;
    logic [DW-1:0] m_dout = '0;

    function automatic bit m_lp_reg();
        return (m_acnt == ATH) || (m_scnt == IDLE);
    endfunction

    // Model update at each rising edge.
    always @(posedge clk) begin
        bit act, advf, brise, off;
        if (!rst_n) begin
            m_acnt = 0; m_scnt = 0; m_armed = 0; m_dout = '0;
            m_paddr = '0; m_pce = 1; m_poe = 1; m_padv = 1; m_pbclk = 0;
        end else begin
            off   = ce_n || !dev_rst_n;
            advf  = m_padv && !adv_n;
            brise = !m_pbclk && bus_clk;
            act   = (addr != m_paddr) || (m_pce && !ce_n) || (m_poe && !oe_n) || advf;
            if (sync_mode || off || oe_n || act) m_acnt = 0;
            else if (m_acnt < ATH) m_acnt++;
            if (!sync_mode || off || advf || brise) m_scnt = 0;
            else if (m_armed && m_scnt < IDLE) m_scnt++;
            if (!sync_mode || off || brise) m_armed = 0;
            else if (advf) m_armed = 1;
            if (!m_lp_reg()) m_dout = array_data;
            m_paddr = addr; m_pce = ce_n; m_poe = oe_n; m_padv = adv_n; m_pbclk = bus_clk;
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare every output on every falling edge.
    always @(negedge clk) begin
        cyc++;
        chk(cur_req, "low_power", 32'(low_power), 32'(!(ce_n || !dev_rst_n) && m_lp_reg()));
        chk(cur_req, "standby", 32'(standby), 32'(ce_n && dev_rst_n));
        chk(cur_req, "data_out", 32'(data_out), 32'(m_dout));
        if (cyc > 200000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            array_data = array_data + 16'h0101;
        end
    endtask

    task automatic at_neg();
        @(negedge clk);
    endtask

    logic [DW-1:0] held;

    initial begin
        // R1: reset state
        cur_req = "R1";
        tick(3);
        at_neg();
        chk("R1", "reset low_power", 32'(low_power), 0);
        chk("R1", "reset data_out", 32'(data_out), 0);
        chk("R1", "reset standby", 32'(standby), 1);
        @(posedge clk); #1 rst_n = 1;

        // R2: async entry after ACC+IDLE quiet edges
        cur_req = "R2";
        @(posedge clk); #1 ce_n = 0; oe_n = 0; addr = 16'h0040;
        tick(ATH);
        at_neg();
        chk("R2", "not yet low", 32'(low_power), 0);
        tick(1); at_neg();
        chk("R2", "entered low", 32'(low_power), 1);

        // R7: data held while low
        cur_req = "R7";
        held = data_out;
        tick(6); at_neg();
        chk("R7", "held data", 32'(data_out), 32'(held));

        // R3: address change exits
        cur_req = "R3";
        @(posedge clk); #1 addr = 16'h0041;
        tick(1); at_neg();
        chk("R3", "addr exit", 32'(low_power), 0);
        tick(ATH + 2);
        at_neg();
        chk("R3", "re-entered", 32'(low_power), 1);
        @(posedge clk); #1 oe_n = 1;
        @(posedge clk); #1 oe_n = 0;
        tick(1); at_neg();
        chk("R3", "oe exit", 32'(low_power), 0);
        tick(ATH + 2);
        @(posedge clk); #1 adv_n = 0;
        @(posedge clk); #1 adv_n = 1;
        tick(1); at_neg();
        chk("R3", "adv exit", 32'(low_power), 0);

        // R4: no read -> no entry
        cur_req = "R4";
        @(posedge clk); #1 oe_n = 1;
        tick(ATH + 10); at_neg();
        chk("R4", "oe high stays awake", 32'(low_power), 0);

        // R5: sync entry after adv fall
        cur_req = "R5";
        @(posedge clk); #1 oe_n = 0; sync_mode = 1;
        tick(2);
        @(posedge clk); #1 adv_n = 0;
        @(posedge clk); #1 adv_n = 1;
        tick(IDLE - 2); at_neg();
        chk("R5", "not yet low", 32'(low_power), 0);
        tick(2); at_neg();
        chk("R5", "sync low", 32'(low_power), 1);

        // R9: address ignored in sync mode
        cur_req = "R9";
        @(posedge clk); #1 addr = 16'h1234;
        tick(2); at_neg();
        chk("R9", "addr ignored", 32'(low_power), 1);

        // R6: clock rise exits and disarms
        cur_req = "R6";
        @(posedge clk); #1 bus_clk = 1;
        tick(1); at_neg();
        chk("R6", "clk exit", 32'(low_power), 0);
        @(posedge clk); #1 bus_clk = 0;
        tick(IDLE + 8); at_neg();
        chk("R6", "stays awake", 32'(low_power), 0);

        // R8: deselect and device reset
        cur_req = "R8";
        @(posedge clk); #1 adv_n = 0;
        @(posedge clk); #1 adv_n = 1;
        tick(IDLE + 2);
        @(posedge clk); #1 ce_n = 1;
        at_neg();
        chk("R8", "standby", 32'(standby), 1);
        chk("R8", "lp off", 32'(low_power), 0);
        @(posedge clk); #1 ce_n = 0; dev_rst_n = 0; sync_mode = 0;
        tick(ATH + 4); at_neg();
        chk("R8", "dev reset standby", 32'(standby), 0);
        chk("R8", "dev reset lp", 32'(low_power), 0);
        @(posedge clk); #1 dev_rst_n = 1;
        tick(ATH + 3); at_neg();
        chk("R2", "entry after dev reset", 32'(low_power), 1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule